// File: doc/BRIEF.md
# Vector Load Lane Distribution Unit

This block sits between a local data memory and a vector register file in an N-lane SIMD datapath. Each cycle it may take a window of bytes already read from memory, cut it into elements of the chosen type (byte, halfword or word, signed or unsigned), and route those elements into the lanes of a destination vector register according to a lane-mapping mode. The modes are: one element per lane in order, broadcast of a single element, a two-element repeating pattern, every second element, each element doubled into two adjacent lanes, a split of even and odd elements into an even/odd register pair, and a free per-lane index table packed into 16-bit parameter words.

The result is registered. One cycle after a valid request the block presents one or two lane vectors with their register indices and write enables. A request that names an odd register or a reserved mode raises an error flag and writes nothing.

A separate path forms the 20-bit load address from two 16-bit parameter words and decides, once per loop iteration, whether the load must be issued. A load is always issued on the first iteration. After that it is issued only when the pointer has moved.

Top module: `vld_dist_unit`

## Requirements
- R1: Mode 0 (in order): lane k of the even register gets element k. Lane k sits at bits [32k+31:32k] of the lane vector. The write goes to register `dst_reg` with `wr_en_even` high and `wr_en_odd` low.
- R2: Mode 1 (broadcast): every lane gets element 0.
- R3: Mode 2 (period-2): even lanes get element 0 and odd lanes get element 1.
- R4: Mode 3 (decimate): lane k gets element 2k.
- R5: Mode 4 (upsample): lane k gets element floor(k/2).
- R6: Mode 5 (pair split): lane k of register `dst_reg` gets element 2k and lane k of register `dst_reg`+1 gets element 2k+1. Both write enables are high.
- R7: Mode 6 (custom): lane k gets element pf[k]. pf[k] is the 4-bit field at bits [(k%4)*4+3:(k%4)*4] of 16-bit word k/4 of `pf_words`; word w sits at bits [16w+15:16w]. With 32 lanes the fields are 5 bits wide, three to a word, and the top bit of each word is unused.
- R8: `etype[1:0]` selects the element size: 0 is a byte, 1 is a halfword, and 2 or 3 is a 32-bit word. `etype[2]`=1 sign-extends the element to the lane width and 0 zero-extends it. Element i takes the bytes starting at byte offset i*size of `window`, little-endian, with byte b at bits [8b+7:8b].
- R9: An odd `dst_reg` or mode 7 sets `err` for one cycle and holds both write enables low.
- R10: The outputs follow a valid request after exactly one clock. A cycle without `in_valid` gives low write enables and low `err` in the next cycle.
- R11: `ld_addr` is {`ptr_hi`[3:0], `ptr_lo`}, registered one cycle after an iteration.
- R12: `ld_issue` is high one cycle after an iteration that is marked first or whose address differs from the previous iteration's address, and low after every other iteration or idle cycle.
- R13: After reset, all write enables, `err` and `ld_issue` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Distribution request valid |
| mode | input | 3 | Lane-mapping mode code |
| etype | input | 3 | Element size and signedness |
| dst_reg | input | 4 | Destination register index (must be even) |
| window | input | 512 | Memory window, 64 bytes |
| pf_words | input | 32 | Packed custom lane indices |
| iter_valid | input | 1 | Loop iteration strobe |
| iter_first | input | 1 | Marks the first iteration of a loop |
| ptr_lo | input | 16 | Even parameter word, low address bits |
| ptr_hi | input | 16 | Odd parameter word, bits [3:0] are the high address bits |
| wr_en_even | output | 1 | Write enable for the even register |
| wr_idx_even | output | 4 | Even register index |
| lanes_even | output | 256 | Lane data for the even register |
| wr_en_odd | output | 1 | Write enable for the odd register |
| wr_idx_odd | output | 4 | Odd register index |
| lanes_odd | output | 256 | Lane data for the odd register |
| err | output | 1 | Illegal request flag |
| ld_issue | output | 1 | Load must be issued this iteration |
| ld_addr | output | 20 | Load address |

## Verification
The assertions assume that `rst` is held for at least one clock before any request. The repeated-address check also assumes that an iteration not marked first always follows a previous iteration in the same loop. The bench starts every loop with `iter_first` high and keeps `iter_valid` and `in_valid` low while reset is active. It changes inputs only on the falling edge, so each request is seen by exactly one rising edge. The expected lane values come from a byte-level model of the window built from the requirements alone.

// File: rtl/vld_pkg.sv
package vld_pkg;

  typedef enum logic [2:0] {
    DM_SEQ    = 3'd0,
    DM_BCAST  = 3'd1,
    DM_CIRC2  = 3'd2,
    DM_DEC2   = 3'd3,
    DM_UP2    = 3'd4,
    DM_PAIR   = 3'd5,
    DM_CUSTOM = 3'd6,
    DM_RSVD   = 3'd7
  } dist_mode_e;

  localparam int unsigned PF_WORD_W = 16;

  // width of one custom lane index field
  function automatic int unsigned cust_idx_w(input int unsigned lanes);
    return (lanes > 16) ? 5 : 4;
  endfunction

  // number of index fields packed in one parameter word
  function automatic int unsigned fields_per_word(input int unsigned lanes);
    return PF_WORD_W / cust_idx_w(lanes);
  endfunction

endpackage

// File: rtl/vld_index_map.sv
module vld_index_map
  import vld_pkg::*;
#(
  parameter int unsigned LANES    = 8,
  parameter int unsigned EIDX_W   = 4,
  parameter int unsigned IDX_W    = 4,
  parameter int unsigned PER_WORD = 4,
  parameter int unsigned PF_WORDS = 2
) (
  input  logic [2:0]                     mode,
  input  logic [PF_WORDS*PF_WORD_W-1:0]  pf_words,
  output logic [LANES-1:0][EIDX_W-1:0]   idx_even,
  output logic [LANES-1:0][EIDX_W-1:0]   idx_odd
);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam int unsigned FIELD_LSB = (k / PER_WORD) * PF_WORD_W + (k % PER_WORD) * IDX_W;
    localparam logic [EIDX_W-1:0] K_SELF = EIDX_W'(k);
    localparam logic [EIDX_W-1:0] K_TWO  = EIDX_W'(2 * k);
    localparam logic [EIDX_W-1:0] K_TWO1 = EIDX_W'(2 * k + 1);
    localparam logic [EIDX_W-1:0] K_HALF = EIDX_W'(k / 2);
    localparam logic [EIDX_W-1:0] K_PAR  = EIDX_W'(k % 2);

    logic [IDX_W-1:0]  cust_field;
    logic [EIDX_W-1:0] sel;

    assign cust_field = pf_words[FIELD_LSB +: IDX_W];

    always_comb begin
      case (dist_mode_e'(mode))
        DM_SEQ:    sel = K_SELF;
        DM_BCAST:  sel = '0;
        DM_CIRC2:  sel = K_PAR;
        DM_DEC2:   sel = K_TWO;
        DM_UP2:    sel = K_HALF;
        DM_PAIR:   sel = K_TWO;
        DM_CUSTOM: sel = EIDX_W'(cust_field);
        default:   sel = '0;
      endcase
    end

    assign idx_even[k] = sel;
    assign idx_odd[k]  = K_TWO1;
  end

endmodule

// File: rtl/vld_lane_fetch.sv
module vld_lane_fetch #(
  parameter int unsigned WIN_BYTES = 64,
  parameter int unsigned EIDX_W    = 4,
  parameter int unsigned LANE_W    = 32
) (
  input  logic [WIN_BYTES*8-1:0] window,
  input  logic [2:0]             etype,
  input  logic [EIDX_W-1:0]      idx,
  output logic [LANE_W-1:0]      elem
);

  localparam int unsigned PW = EIDX_W + 3;
  localparam logic [PW-1:0] LIMIT = PW'(WIN_BYTES);

  logic [PW-1:0] base;
  logic [7:0]    bt [4];
  logic          sgn;

  assign sgn = etype[2];

  always_comb begin
    case (etype[1:0])
      2'd0:    base = {3'b000, idx};
      2'd1:    base = {2'b00, idx, 1'b0};
      default: base = {1'b0, idx, 2'b00};
    endcase
  end

  for (genvar j = 0; j < 4; j++) begin : g_byte
    localparam logic [PW-1:0] OFS = PW'(j);
    logic [PW-1:0] pos;
    assign pos   = base + OFS;
    assign bt[j] = (pos < LIMIT) ? window[pos*8 +: 8] : 8'h00;
  end

  always_comb begin
    case (etype[1:0])
      2'd0:    elem = {{(LANE_W-8){sgn & bt[0][7]}}, bt[0]};
      2'd1:    elem = {{(LANE_W-16){sgn & bt[1][7]}}, bt[1], bt[0]};
      default: elem = LANE_W'({bt[3], bt[2], bt[1], bt[0]});
    endcase
  end

endmodule

// File: rtl/vld_issue_pred.sv
module vld_issue_pred #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned HI_W   = 4,
  localparam int unsigned ADDR_W = WORD_W + HI_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iter_valid,
  input  logic              iter_first,
  input  logic [WORD_W-1:0] ptr_lo,
  input  logic [WORD_W-1:0] ptr_hi,
  output logic              ld_issue,
  output logic [ADDR_W-1:0] ld_addr
);

  logic [ADDR_W-1:0] addr_c;
  logic [ADDR_W-1:0] prev_addr;
  logic              have_prev;
  logic              unused_hi;

  assign addr_c    = {ptr_hi[HI_W-1:0], ptr_lo};
  assign unused_hi = ^ptr_hi[WORD_W-1:HI_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_issue  <= 1'b0;
      ld_addr   <= '0;
      prev_addr <= '0;
      have_prev <= 1'b0;
    end else begin
      ld_issue <= iter_valid && (iter_first || !have_prev || (addr_c != prev_addr));
      if (iter_valid) begin
        ld_addr   <= addr_c;
        prev_addr <= addr_c;
        have_prev <= 1'b1;
      end
    end
  end

  assert_first_issue_R12: assert property (@(posedge clk) disable iff (rst)
    (iter_valid && iter_first) |=> ld_issue);

  assert_still_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(iter_valid) && iter_valid && !iter_first &&
     ({ptr_hi[HI_W-1:0], ptr_lo} == $past({ptr_hi[HI_W-1:0], ptr_lo}))) |=> !ld_issue);

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    !iter_valid |=> !ld_issue);

  assert_addr_join_R11: assert property (@(posedge clk) disable iff (rst)
    iter_valid |=> (ld_addr[ADDR_W-1:WORD_W] == $past(ptr_hi[HI_W-1:0])) &&
                   (ld_addr[WORD_W-1:0] == $past(ptr_lo)));

endmodule

// File: rtl/vld_dist_unit.sv
module vld_dist_unit
  import vld_pkg::*;
#(
  parameter int unsigned LANES  = 8,
  parameter int unsigned LANE_W = 32,
  parameter int unsigned NREGS  = 16,
  parameter int unsigned HI_W   = 4,
  localparam int unsigned RIDX_W    = $clog2(NREGS),
  localparam int unsigned WIN_BYTES = 2 * LANES * 4,
  localparam int unsigned IDX_W     = cust_idx_w(LANES),
  localparam int unsigned PER_WORD  = fields_per_word(LANES),
  localparam int unsigned PF_WORDS  = (LANES + PER_WORD - 1) / PER_WORD,
  localparam int unsigned NAT_W     = $clog2(2 * LANES),
  localparam int unsigned EIDX_W    = (NAT_W > IDX_W) ? NAT_W : IDX_W,
  localparam int unsigned ADDR_W    = PF_WORD_W + HI_W
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          in_valid,
  input  logic [2:0]                    mode,
  input  logic [2:0]                    etype,
  input  logic [RIDX_W-1:0]             dst_reg,
  input  logic [WIN_BYTES*8-1:0]        window,
  input  logic [PF_WORDS*PF_WORD_W-1:0] pf_words,
  input  logic                          iter_valid,
  input  logic                          iter_first,
  input  logic [PF_WORD_W-1:0]          ptr_lo,
  input  logic [PF_WORD_W-1:0]          ptr_hi,
  output logic                          wr_en_even,
  output logic [RIDX_W-1:0]             wr_idx_even,
  output logic [LANES*LANE_W-1:0]       lanes_even,
  output logic                          wr_en_odd,
  output logic [RIDX_W-1:0]             wr_idx_odd,
  output logic [LANES*LANE_W-1:0]       lanes_odd,
  output logic                          err,
  output logic                          ld_issue,
  output logic [ADDR_W-1:0]             ld_addr
);

  logic [LANES-1:0][EIDX_W-1:0] idx_even;
  logic [LANES-1:0][EIDX_W-1:0] idx_odd;
  logic [LANES-1:0][LANE_W-1:0] even_c;
  logic [LANES-1:0][LANE_W-1:0] odd_c;
  logic [LANES-1:0][LANE_W-1:0] even_q;
  logic [LANES-1:0][LANE_W-1:0] odd_q;
  logic                         bad_req;
  logic                         is_pair;

  vld_index_map #(
    .LANES(LANES), .EIDX_W(EIDX_W), .IDX_W(IDX_W),
    .PER_WORD(PER_WORD), .PF_WORDS(PF_WORDS)
  ) u_map (
    .mode(mode), .pf_words(pf_words),
    .idx_even(idx_even), .idx_odd(idx_odd)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_fetch
    vld_lane_fetch #(.WIN_BYTES(WIN_BYTES), .EIDX_W(EIDX_W), .LANE_W(LANE_W)) u_even (
      .window(window), .etype(etype), .idx(idx_even[k]), .elem(even_c[k])
    );
    vld_lane_fetch #(.WIN_BYTES(WIN_BYTES), .EIDX_W(EIDX_W), .LANE_W(LANE_W)) u_odd (
      .window(window), .etype(etype), .idx(idx_odd[k]), .elem(odd_c[k])
    );
  end

  assign bad_req = dst_reg[0] || (dist_mode_e'(mode) == DM_RSVD);
  assign is_pair = (dist_mode_e'(mode) == DM_PAIR);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en_even  <= 1'b0;
      wr_en_odd   <= 1'b0;
      err         <= 1'b0;
      wr_idx_even <= '0;
      wr_idx_odd  <= '0;
      even_q      <= '0;
      odd_q       <= '0;
    end else begin
      wr_en_even <= in_valid && !bad_req;
      wr_en_odd  <= in_valid && !bad_req && is_pair;
      err        <= in_valid && bad_req;
      if (in_valid) begin
        wr_idx_even <= dst_reg;
        wr_idx_odd  <= dst_reg | RIDX_W'(1);
        even_q      <= even_c;
        odd_q       <= odd_c;
      end
    end
  end

  assign lanes_even = even_q;
  assign lanes_odd  = odd_q;

  vld_issue_pred #(.WORD_W(PF_WORD_W), .HI_W(HI_W)) u_issue (
    .clk(clk), .rst(rst), .iter_valid(iter_valid), .iter_first(iter_first),
    .ptr_lo(ptr_lo), .ptr_hi(ptr_hi), .ld_issue(ld_issue), .ld_addr(ld_addr)
  );

  assert_odd_dst_blocked_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dst_reg[0]) |=> (err && !wr_en_even && !wr_en_odd));

  assert_rsvd_mode_blocked_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 3'd7) |=> (err && !wr_en_even && !wr_en_odd));

  assert_idle_no_write_R10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!wr_en_even && !wr_en_odd && !err));

  assert_pair_both_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 3'd5 && !dst_reg[0]) |=>
      (wr_en_even && wr_en_odd && wr_idx_odd == (wr_idx_even | RIDX_W'(1))));

  assert_single_only_R1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode != 3'd5) |=> !wr_en_odd);

  assert_bcast_uniform_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 3'd1 && !dst_reg[0]) |=>
      (lanes_even[LANES*LANE_W-1 -: LANE_W] == lanes_even[LANE_W-1:0]));

endmodule

// File: tb/tb_vld_dist_unit.sv
module tb_vld_dist_unit;
  localparam int LANES = 8;
  localparam int LW    = 32;
  localparam int WB    = 64;
  localparam int VW    = LANES * LW;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic            rst, in_valid, iter_valid, iter_first;
  logic [2:0]      mode, etype;
  logic [3:0]      dst_reg;
  logic [WB*8-1:0] window;
  logic [31:0]     pf_words;
  logic [15:0]     ptr_lo, ptr_hi;
  logic            wr_en_even, wr_en_odd, err, ld_issue;
  logic [3:0]      wr_idx_even, wr_idx_odd;
  logic [VW-1:0]   lanes_even, lanes_odd;
  logic [19:0]     ld_addr;

  vld_dist_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .etype(etype),
    .dst_reg(dst_reg), .window(window), .pf_words(pf_words),
    .iter_valid(iter_valid), .iter_first(iter_first), .ptr_lo(ptr_lo), .ptr_hi(ptr_hi),
    .wr_en_even(wr_en_even), .wr_idx_even(wr_idx_even), .lanes_even(lanes_even),
    .wr_en_odd(wr_en_odd), .wr_idx_odd(wr_idx_odd), .lanes_odd(lanes_odd),
    .err(err), .ld_issue(ld_issue), .ld_addr(ld_addr)
  );

  int n_chk  = 0;
  int n_fail = 0;
  logic [7:0] wbytes [WB];

  task automatic chk(input string req, input string what, input logic [VW-1:0] got, input logic [VW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic set_window(input int seed);
    for (int i = 0; i < WB; i++) begin
      wbytes[i] = 8'((i * 37 + seed * 11 + 8'h91) & 8'hff);
      window[i*8 +: 8] = wbytes[i];
    end
  endtask

  function automatic logic [31:0] exp_elem(input int idx, input logic [2:0] et);
    int sz;
    logic [31:0] v;
    sz = (et[1:0] == 2'd0) ? 1 : (et[1:0] == 2'd1) ? 2 : 4;
    v = '0;
    for (int j = 0; j < sz; j++)
      if (idx * sz + j < WB) v[j*8 +: 8] = wbytes[idx * sz + j];
    if (et[2] && sz == 1 && v[7])  v[31:8]  = '1;
    if (et[2] && sz == 2 && v[15]) v[31:16] = '1;
    return v;
  endfunction

  function automatic logic [VW-1:0] exp_vec(input int md, input logic [2:0] et, input logic [31:0] pf, input bit odd);
    logic [VW-1:0] r;
    int e;
    r = '0;
    for (int k = 0; k < LANES; k++) begin
      case (md)
        0: e = k;
        1: e = 0;
        2: e = k % 2;
        3: e = 2 * k;
        4: e = k / 2;
        5: e = odd ? 2 * k + 1 : 2 * k;
        default: e = int'(pf[k*4 +: 4]);
      endcase
      r[k*LW +: LW] = exp_elem(e, et);
    end
    return r;
  endfunction

  task automatic run_load(input string req, input int md, input logic [2:0] et, input logic [3:0] dst, input logic [31:0] pf);
    @(negedge clk);
    mode = 3'(md); etype = et; dst_reg = dst; pf_words = pf; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(req, "wr_en_even", VW'(wr_en_even), VW'(1));
    chk(req, "wr_idx_even", VW'(wr_idx_even), VW'(dst));
    chk(req, "lanes_even", lanes_even, exp_vec(md, et, pf, 1'b0));
    chk(req, "wr_en_odd", VW'(wr_en_odd), VW'(md == 5));
    chk(req, "err", VW'(err), VW'(0));
    if (md == 5) begin
      chk(req, "wr_idx_odd", VW'(wr_idx_odd), VW'(dst + 4'd1));
      chk(req, "lanes_odd", lanes_odd, exp_vec(md, et, pf, 1'b1));
    end
  endtask

  task automatic t_reset_R13;
    rst = 1'b1; in_valid = 1'b0; iter_valid = 1'b0; iter_first = 1'b0;
    mode = '0; etype = '0; dst_reg = '0; pf_words = '0; ptr_lo = '0; ptr_hi = '0;
    set_window(0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R13", "wr_en_even", VW'(wr_en_even), VW'(0));
    chk("R13", "wr_en_odd", VW'(wr_en_odd), VW'(0));
    chk("R13", "err", VW'(err), VW'(0));
    chk("R13", "ld_issue", VW'(ld_issue), VW'(0));
  endtask

  task automatic t_modes;
    run_load("R1", 0, 3'd2, 4'd0, '0);
    run_load("R1", 0, 3'd0, 4'd6, '0);
    run_load("R2", 1, 3'd6, 4'd4, '0);
    run_load("R3", 2, 3'd1, 4'd8, '0);
    run_load("R4", 3, 3'd2, 4'd10, '0);
    run_load("R5", 4, 3'd4, 4'd12, '0);
    run_load("R6", 5, 3'd2, 4'd14, '0);
    run_load("R6", 5, 3'd5, 4'd2, '0);
  endtask

  task automatic t_custom_R7;
    run_load("R7", 6, 3'd5, 4'd0, 32'hC229_70F3);
    run_load("R7", 6, 3'd2, 4'd6, 32'h0123_FEDC);
  endtask

  task automatic t_types_R8;
    logic [2:0] ets [6] = '{3'd0, 3'd1, 3'd2, 3'd4, 3'd5, 3'd6};
    set_window(5);
    foreach (ets[i]) begin
      run_load("R8", 0, ets[i], 4'd2, '0);
      run_load("R8", 3, ets[i], 4'd4, '0);
    end
    run_load("R8", 0, 3'd3, 4'd8, '0);
  endtask

  task automatic t_errors_R9;
    @(negedge clk);
    mode = 3'd0; etype = 3'd2; dst_reg = 4'd3; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9", "err odd dst", VW'(err), VW'(1));
    chk("R9", "wr_en_even odd dst", VW'(wr_en_even), VW'(0));
    chk("R9", "wr_en_odd odd dst", VW'(wr_en_odd), VW'(0));
    @(negedge clk);
    mode = 3'd7; dst_reg = 4'd2; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9", "err rsvd mode", VW'(err), VW'(1));
    chk("R9", "wr_en_even rsvd", VW'(wr_en_even), VW'(0));
    @(negedge clk);
    mode = 3'd5; dst_reg = 4'd5; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9", "wr_en_odd pair odd dst", VW'(wr_en_odd), VW'(0));
  endtask

  task automatic t_idle_R10;
    @(negedge clk);
    mode = 3'd0; dst_reg = 4'd0; in_valid = 1'b0;
    @(negedge clk);
    chk("R10", "wr_en_even idle", VW'(wr_en_even), VW'(0));
    chk("R10", "err idle", VW'(err), VW'(0));
  endtask

  task automatic iter(input string req, input bit first, input logic [15:0] lo, input logic [15:0] hi, input bit exp_issue);
    @(negedge clk);
    iter_valid = 1'b1; iter_first = first; ptr_lo = lo; ptr_hi = hi;
    @(negedge clk);
    iter_valid = 1'b0; iter_first = 1'b0;
    chk(req, "ld_issue", VW'(ld_issue), VW'(exp_issue));
    chk("R11", "ld_addr", VW'(ld_addr), VW'({hi[3:0], lo}));
  endtask

  task automatic t_issue_R12;
    iter("R12", 1'b1, 16'h1234, 16'hFFF5, 1'b1);
    iter("R12", 1'b0, 16'h1234, 16'h0005, 1'b0);
    iter("R12", 1'b0, 16'h1238, 16'h0005, 1'b1);
    iter("R12", 1'b0, 16'h1238, 16'h0006, 1'b1);
    iter("R12", 1'b0, 16'h1238, 16'h0006, 1'b0);
    iter("R12", 1'b1, 16'h1238, 16'h0006, 1'b1);
    @(negedge clk);
    chk("R12", "ld_issue idle", VW'(ld_issue), VW'(0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset_R13();
    t_modes();
    t_custom_R7();
    t_types_R8();
    t_errors_R9();
    t_idle_R10();
    t_issue_R12();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule